// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steps a 7-bit control address through a 128-entry by 20-bit control store, one microword per clock. Each microword carries three independent 3-bit micro-operation fields, a 2-bit condition selector, a 2-bit branch kind and a 7-bit target address. The fields are decoded into one-hot strobes. The condition and branch kind together choose the next control address: a conditional jump, a conditional call, a return, or an opcode dispatch.

A small datapath is included so that the instruction fetch sequence can run from end to end. It has a program counter, an address register, a data register and a 2048 x 16 main memory. No instruction register exists, so the fetched word stays in the data register. Both memories are filled through write ports, normally while reset is held. The accumulator is outside this block and is seen only as an input for the condition tests.

Top module: `mseq_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control address becomes 64, PC, AR and DR become 0, and the saved return address becomes 0.
- R2: The microword is laid out from bit 19 down as F1[19:17], F2[16:14], F3[13:11], CD[10:9], BR[8:7], AD[6:0]. For each field, code k (1 to 7) raises strobe bit k-1 of that field's strobe output during the cycle the word is current. Code 000 raises none.
- R3: F1=110 loads AR from PC. F1=101 loads AR from DR[10:0].
- R4: F2=100 loads DR from main memory at address AR. F3=101 increments PC, wrapping modulo 2048.
- R5: CD selects the condition: 00 always true, 01 DR[15], 10 `acc_in`[15], 11 `acc_in` equal to zero.
- R6: BR=00 loads AD into the control address when the condition is true. Otherwise the control address increments by one.
- R7: BR=01 behaves like BR=00, but when the condition is true it also stores the incremented address as the return address. When the condition is false the stored return address is unchanged.
- R8: BR=10 loads the stored return address into the control address.
- R9: BR=11 sets control address bits 5:2 from DR[14:11] and clears bits 6, 1 and 0.
- R10: A microword whose F1, F2 and F3 codes are not among the codes in R3 and R4 leaves PC, AR and DR unchanged.
- R11: With the three fetch words at 64, 65 and 66, fetching from PC=n ends in the cycle after word 66 with AR = M[n][10:0], PC = n+1, DR = M[n] and the control address equal to 4 x M[n][14:11]. Writes made through the memory load ports are visible to later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cm_we | input | 1 | Control store write enable |
| cm_waddr | input | 7 | Control store write address |
| cm_wdata | input | 20 | Control store write data |
| mm_we | input | 1 | Main memory write enable |
| mm_waddr | input | 11 | Main memory write address |
| mm_wdata | input | 16 | Main memory write data |
| acc_in | input | 16 | Accumulator value for the condition tests |
| car_o | output | 7 | Current control address |
| pc_o | output | 11 | Program counter |
| ar_o | output | 11 | Address register |
| dr_o | output | 16 | Data register |
| f1_stb_o | output | 7 | One-hot strobes of field F1 |
| f2_stb_o | output | 7 | One-hot strobes of field F2 |
| f3_stb_o | output | 7 | One-hot strobes of field F3 |

## Verification
The assertions check the following on every cycle: that each datapath strobe has its register effect one edge later, that PC and AR hold when no strobe targets them, that return and dispatch load the expected control address, and that the address after reset is 64. Only the bench scenarios can show the rest. These are the decision made by each condition code under both outcomes, whether a call that is not taken saves anything, and the full fetch and dispatch over all 16 opcodes with both values of the top bit.

// File: rtl/mseq_pkg.sv
// Package: shared widths, microword layout and field codes of the sequencer.
// Assumes a 20-bit microword and a 16-bit data word whose opcode sits below bit 15.
package mseq_pkg;
    localparam int CA_W    = 7;
    localparam int UW_W    = 20;
    localparam int FLD_W   = 3;
    localparam int NCODE   = (1 << FLD_W) - 1;
    localparam int NFLD    = 3;
    localparam int MA_W    = 11;
    localparam int D_W     = 16;
    localparam int OP_W    = 4;
    localparam logic [CA_W-1:0] FETCH_ORG = 7'd64;

    localparam logic [FLD_W-1:0] F1_DR2AR = 3'd5;
    localparam logic [FLD_W-1:0] F1_PC2AR = 3'd6;
    localparam logic [FLD_W-1:0] F2_MREAD = 3'd4;
    localparam logic [FLD_W-1:0] F3_PCINC = 3'd5;

    typedef enum logic [1:0] {CD_ALWAYS, CD_INDIR, CD_SIGN, CD_ZERO} cond_e;
    typedef enum logic [1:0] {BR_JUMP, BR_CALL, BR_RETURN, BR_DISPATCH} brk_e;

    typedef struct packed {
        logic [FLD_W-1:0] f1;
        logic [FLD_W-1:0] f2;
        logic [FLD_W-1:0] f3;
        cond_e            cd;
        brk_e             br;
        logic [CA_W-1:0]  ad;
    } uword_t;
endpackage

// File: rtl/mseq_cstore.sv
// Control store with a write port and one-hot decoding of the three op fields.
// Assumes the store is filled before use; reads are combinational on the address.
module mseq_cstore
    import mseq_pkg::*;
#(
    parameter int AW = CA_W,
    parameter int WW = UW_W
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [AW-1:0]               waddr,
    input  logic [WW-1:0]               wdata,
    input  logic [AW-1:0]               car,
    output uword_t                      uw,
    output logic [NFLD-1:0][NCODE-1:0]  stb
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0]    store [DEPTH];
    logic [FLD_W-1:0] fld   [NFLD];

    // Store write port.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign uw     = uword_t'(store[car]);
    assign fld[0] = uw.f1;
    assign fld[1] = uw.f2;
    assign fld[2] = uw.f3;

    // One strobe per nonzero code of each field.
    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        for (genvar k = 0; k < NCODE; k++) begin : g_code
            assign stb[g][k] = (fld[g] == FLD_W'(k + 1));
        end
    end
endmodule

// File: rtl/mseq_next.sv
// Next-address logic: condition select, jump, call, return and opcode dispatch.
// Assumes one return level; the dispatch gives each opcode four words.
module mseq_next
    import mseq_pkg::*;
#(
    parameter int AW = CA_W,
    parameter int DW = D_W,
    parameter int OW = OP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cond_e         cd,
    input  brk_e          br,
    input  logic [AW-1:0] ad,
    input  logic          dr_ind,
    input  logic [OW-1:0] dr_op,
    input  logic [DW-1:0] acc,
    output logic [AW-1:0] car
);
    logic [AW-1:0] ret_q;
    logic [AW-1:0] inc;
    logic [AW-1:0] nxt;
    logic          cond;

    assign inc = car + AW'(1);

    // Pick the branch condition.
    always_comb begin
        unique case (cd)
            CD_ALWAYS: cond = 1'b1;
            CD_INDIR:  cond = dr_ind;
            CD_SIGN:   cond = acc[DW-1];
            CD_ZERO:   cond = (acc == '0);
        endcase
    end

    // Form the next control address.
    always_comb begin
        unique case (br)
            BR_JUMP, BR_CALL: nxt = cond ? ad : inc;
            BR_RETURN:        nxt = ret_q;
            BR_DISPATCH:      nxt = AW'({dr_op, 2'b00});
        endcase
    end

    // Control address and return register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car   <= FETCH_ORG;
            ret_q <= '0;
        end else begin
            car <= nxt;
            if (br == BR_CALL && cond) ret_q <= inc;
        end
    end

    AST_RESET_ORG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> car == FETCH_ORG); // R1
    AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (br == BR_JUMP && cd == CD_ALWAYS) |=> car == $past(ad)); // R6
    AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (br == BR_RETURN) |=> car == $past(ret_q)); // R8
    AST_DISPATCH_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (br == BR_DISPATCH) |=> (car[1:0] == 2'b00 && car[5:2] == $past(dr_op) && !car[6])); // R9
endmodule

// File: rtl/mseq_dpath.sv
// Minimal fetch datapath: PC, AR, DR and main memory with a write port.
// Assumes that at most one AR load strobe is active per cycle.
module mseq_dpath
    import mseq_pkg::*;
#(
    parameter int AW = MA_W,
    parameter int DW = D_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mm_we,
    input  logic [AW-1:0] mm_waddr,
    input  logic [DW-1:0] mm_wdata,
    input  logic          ar_from_pc,
    input  logic          ar_from_dr,
    input  logic          dr_from_mem,
    input  logic          pc_step,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] ar,
    output logic [DW-1:0] dr
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_word;

    assign rd_word = mem[ar];

    // Main memory write port.
    always_ff @(posedge clk) begin
        if (mm_we) mem[mm_waddr] <= mm_wdata;
    end

    // Register transfers driven by the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
            ar <= '0;
            dr <= '0;
        end else begin
            if (ar_from_pc)       ar <= pc;
            else if (ar_from_dr)  ar <= dr[AW-1:0];
            if (dr_from_mem)      dr <= rd_word;
            if (pc_step)          pc <= pc + AW'(1);
        end
    end

    AST_PC_TO_AR: assert property (@(posedge clk) disable iff (!rst_n)
        ar_from_pc |=> ar == $past(pc)); // R3
    AST_DR_TO_AR: assert property (@(posedge clk) disable iff (!rst_n)
        ar_from_dr |=> ar == $past(dr[AW-1:0])); // R3
    AST_MEM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_from_mem && !mm_we) |=> dr == $past(rd_word)); // R4
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pc_step |=> pc == $past(pc) + AW'(1)); // R4
    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_step |=> $stable(pc)); // R10
    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ar_from_pc && !ar_from_dr) |=> $stable(ar)); // R10
    AST_DR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !dr_from_mem |=> $stable(dr)); // R10
endmodule

// File: rtl/mseq_top.sv
// Top of the microprogrammed sequencer: control store, next-address logic and
// fetch datapath. Assumes both memories are loaded through the ports while in reset.
module mseq_top
    import mseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cm_we,
    input  logic [CA_W-1:0]  cm_waddr,
    input  logic [UW_W-1:0]  cm_wdata,
    input  logic             mm_we,
    input  logic [MA_W-1:0]  mm_waddr,
    input  logic [D_W-1:0]   mm_wdata,
    input  logic [D_W-1:0]   acc_in,
    output logic [CA_W-1:0]  car_o,
    output logic [MA_W-1:0]  pc_o,
    output logic [MA_W-1:0]  ar_o,
    output logic [D_W-1:0]   dr_o,
    output logic [NCODE-1:0] f1_stb_o,
    output logic [NCODE-1:0] f2_stb_o,
    output logic [NCODE-1:0] f3_stb_o
);
    uword_t                     uw;
    logic [NFLD-1:0][NCODE-1:0] stb;

    mseq_cstore #(.AW(CA_W), .WW(UW_W)) cstore_i (
        .clk   (clk),
        .we    (cm_we),
        .waddr (cm_waddr),
        .wdata (cm_wdata),
        .car   (car_o),
        .uw    (uw),
        .stb   (stb)
    );

    mseq_next #(.AW(CA_W), .DW(D_W), .OW(OP_W)) next_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cd     (uw.cd),
        .br     (uw.br),
        .ad     (uw.ad),
        .dr_ind (dr_o[D_W-1]),
        .dr_op  (dr_o[D_W-2 -: OP_W]),
        .acc    (acc_in),
        .car    (car_o)
    );

    mseq_dpath #(.AW(MA_W), .DW(D_W)) dpath_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mm_we       (mm_we),
        .mm_waddr    (mm_waddr),
        .mm_wdata    (mm_wdata),
        .ar_from_pc  (stb[0][F1_PC2AR-1]),
        .ar_from_dr  (stb[0][F1_DR2AR-1]),
        .dr_from_mem (stb[1][F2_MREAD-1]),
        .pc_step     (stb[2][F3_PCINC-1]),
        .pc          (pc_o),
        .ar          (ar_o),
        .dr          (dr_o)
    );

    assign f1_stb_o = stb[0];
    assign f2_stb_o = stb[1];
    assign f3_stb_o = stb[2];

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot0(f1_stb_o) && $onehot0(f2_stb_o) && $onehot0(f3_stb_o))); // R2
endmodule

// File: tb/mseq_top_tb.sv
`timescale 1ns/1ps
// Bench: fetch and dispatch sweep over every opcode and top bit, then a sweep of
// condition codes, outcomes and jump/call kinds followed by returns.
module mseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cm_we = 1'b0;
    logic [6:0]  cm_waddr = '0;
    logic [19:0] cm_wdata = '0;
    logic        mm_we = 1'b0;
    logic [10:0] mm_waddr = '0;
    logic [15:0] mm_wdata = '0;
    logic [15:0] acc_in = '0;
    logic [6:0]  car_o;
    logic [10:0] pc_o, ar_o;
    logic [15:0] dr_o;
    logic [6:0]  f1_stb_o, f2_stb_o, f3_stb_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    mseq_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .cm_we(cm_we), .cm_waddr(cm_waddr), .cm_wdata(cm_wdata),
        .mm_we(mm_we), .mm_waddr(mm_waddr), .mm_wdata(mm_wdata),
        .acc_in(acc_in),
        .car_o(car_o), .pc_o(pc_o), .ar_o(ar_o), .dr_o(dr_o),
        .f1_stb_o(f1_stb_o), .f2_stb_o(f2_stb_o), .f3_stb_o(f3_stb_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [19:0] mk(input int f1, input int f2, input int f3,
                                       input int cd, input int br, input int ad);
        return {3'(f1), 3'(f2), 3'(f3), 2'(cd), 2'(br), 7'(ad)};
    endfunction

    task automatic cm_write(input int a, input logic [19:0] d);
        cm_we = 1'b1; cm_waddr = 7'(a); cm_wdata = d;
        tick();
        cm_we = 1'b0;
    endtask

    task automatic mm_write(input int a, input logic [15:0] d);
        mm_we = 1'b1; mm_waddr = 11'(a); mm_wdata = d;
        tick();
        mm_we = 1'b0;
    endtask

    function automatic logic [15:0] instr(input int i);
        logic [10:0] a;
        a = 11'((i * 37 + 5) % 2048);
        return {1'(i / 16), 4'(i % 16), a};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R11 watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick();
        // Fetch words and an opcode slot that returns to fetch.
        cm_write(64, mk(6, 0, 0, 0, 0, 65));
        cm_write(65, mk(0, 4, 5, 0, 0, 66));
        cm_write(66, mk(5, 0, 0, 0, 3, 0));
        for (int op = 0; op < 16; op++) cm_write(op * 4, mk(0, 0, 0, 0, 0, 64));
        for (int i = 0; i < 32; i++) mm_write(i, instr(i));
        // R1: reset state
        chk("R1 car", 32'(car_o), 32'd64);
        chk("R1 pc", 32'(pc_o), 32'd0);
        chk("R1 ar", 32'(ar_o), 32'd0);
        chk("R1 dr", 32'(dr_o), 32'd0);
        rst_n = 1'b1;
        // R2: strobes of word 64
        chk("R2 f1 at 64", 32'(f1_stb_o), 32'h20);
        chk("R2 f2 at 64", 32'(f2_stb_o), 32'h00);
        chk("R2 f3 at 64", 32'(f3_stb_o), 32'h00);
        tick();
        chk("R3 ar from pc", 32'(ar_o), 32'd0);
        chk("R6 car 65", 32'(car_o), 32'd65);
        chk("R2 f2 at 65", 32'(f2_stb_o), 32'h08);
        chk("R2 f3 at 65", 32'(f3_stb_o), 32'h10);
        for (int i = 0; i < 32; i++) begin
            tick();
            chk("R4 dr read", 32'(dr_o), 32'(instr(i)));
            chk("R4 pc step", 32'(pc_o), 32'(i + 1));
            chk("R6 car 66", 32'(car_o), 32'd66);
            tick();
            chk("R3 ar from dr", 32'(ar_o), 32'(instr(i) & 16'h07ff));
            chk("R9 dispatch", 32'(car_o), 32'((i % 16) * 4));
            chk("R11 dr kept", 32'(dr_o), 32'(instr(i)));
            tick();
            chk("R6 back to fetch", 32'(car_o), 32'd64);
            chk("R10 ar hold", 32'(ar_o), 32'(instr(i) & 16'h07ff));
            chk("R10 pc hold", 32'(pc_o), 32'(i + 1));
            chk("R10 dr hold", 32'(dr_o), 32'(instr(i)));
            tick();
            chk("R11 next ar", 32'(ar_o), 32'(i + 1));
        end

        // Condition and branch kind sweep; word 100 and 13 return.
        for (int cd = 0; cd < 4; cd++) begin
            for (int v = 0; v < 2; v++) begin
                for (int br = 0; br < 2; br++) begin
                    logic ib;
                    logic cond;
                    int   e1;
                    int   e2;
                    rst_n = 1'b0;
                    ib = (cd == 1) ? 1'(v) : 1'(1 - v);
                    case (cd)
                        2: acc_in = v ? 16'h8000 : 16'h7fff;
                        3: acc_in = v ? 16'h0000 : 16'h0040;
                        default: acc_in = 16'h1234;
                    endcase
                    cond = (cd == 0) ? 1'b1 : 1'(v);
                    cm_write(12, mk(0, 0, 0, cd, br, 100));
                    cm_write(13, mk(0, 0, 0, 0, 2, 0));
                    cm_write(100, mk(0, 0, 0, 0, 2, 0));
                    mm_write(0, {ib, 4'd3, 11'd7});
                    rst_n = 1'b1;
                    tick(); tick(); tick();
                    chk("R11 dispatch 12", 32'(car_o), 32'd12);
                    tick();
                    e1 = cond ? 100 : 13;
                    chk((br == 1) ? "R7 call target" : "R5 R6 jump target", 32'(car_o), 32'(e1));
                    tick();
                    e2 = (br == 1 && cond) ? 13 : 0;
                    chk((br == 1) ? "R7 R8 saved return" : "R8 return", 32'(car_o), 32'(e2));
                end
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule